// File: doc/BRIEF.md
# Floating-Point Mantissa Truncation Packer and Unpacker

This block shortens a stream of 32-bit single-precision floating-point words to save storage and link bandwidth. For each transfer a truncation count k is chosen at run time, and the k least significant mantissa bits are removed from every word. The remaining (32-k)-bit fields are packed end to end, with no gaps, into 128-bit beats. The last beat of a transfer is zero-filled and flagged. The count in force is reported beside every output beat, so that it can be stored as metadata with the data.

A separate unpacker path reverses the process. It is given the stored count and the number of words in the transfer. It consumes exactly the beats that hold those words and emits 32-bit words, each field moved back to its original position with zeros in the low k bits. Both paths use valid/ready handshakes on their input and output streams.

Top module: `fptrunc_codec`

## Requirements
- R1: Each packed field is bits [31:k] of its input word. Fields are placed from bit 0 of a beat upward, in arrival order, with the first word lowest.
- R2: A configured truncation count above 23 is treated as 23. The sign and exponent bits are therefore never removed.
- R3: A beat is emitted as soon as 128 field bits have gathered. A field that crosses a beat boundary continues at bit 0 of the next beat, with no padding between fields.
- R4: The word flagged last closes the transfer. Bits left over go out in a final beat padded with zeros above them, and only the final beat carries the last flag. If the final field overruns a full beat, one extra closing beat follows.
- R5: The truncation count is sampled when the first word of a transfer is accepted. Changes to the count input later in that transfer have no effect on it.
- R6: The reported count output equals the count in force for the transfer on every output beat.
- R7: While an output is valid and not accepted, the output and its flags hold steady.
- R8: The unpacker emits each word as its field shifted left by k, with zeros in bits [k-1:0].
- R9: The unpacker samples its count and word total when it is idle and a beat is offered. It consumes exactly the beats holding that many words, discards the padding, and then returns to idle. A word total of zero does not start a transfer.
- R10: With k = 0 the packed beats are the raw words in order, and the unpacker reproduces them unchanged.
- R11: After reset neither output stream is valid, the packer input is ready and the unpacker input is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTrunc | input | 5 | Truncation count for the next packer transfer |
| pkInValid | input | 1 | Packer input word valid |
| pkInReady | output | 1 | Packer can accept a word |
| pkInWord | input | 32 | Packer input float word |
| pkInLast | input | 1 | Marks the final word of a transfer |
| pkOutValid | output | 1 | Packed beat valid |
| pkOutReady | input | 1 | Downstream accepts the packed beat |
| pkOutBeat | output | 128 | Packed beat |
| pkOutLast | output | 1 | Final beat of the transfer |
| pkOutTrunc | output | 5 | Truncation count in force, for metadata |
| upTrunc | input | 5 | Stored truncation count for the unpacker |
| upCount | input | 16 | Number of words in the unpacker transfer |
| upInValid | input | 1 | Packed beat offered to the unpacker |
| upInReady | output | 1 | Unpacker accepts the beat |
| upInBeat | input | 128 | Packed beat into the unpacker |
| upOutValid | output | 1 | Restored word valid |
| upOutReady | input | 1 | Downstream accepts the restored word |
| upOutWord | output | 32 | Restored 32-bit word |

## Verification
The bench targets these corner cases:
- Fields that straddle a beat boundary. An accumulator that dropped the carried remainder would lose bits.
- A transfer whose bits end exactly on a beat boundary. This would reveal a spurious empty closing beat.
- A final field that overruns a beat. A design that forgot the extra closing beat would show this.
- A count above the legal range. Sign or exponent bits would be destroyed without the clamp.
- A count changed in mid-transfer. A design that re-sampled it would misalign every later field.

Randomised backpressure on both outputs shows whether held data changes. Unpacking the model's beats shows whether the unpacker consumes padding or leaves a beat behind.

// File: rtl/fptrunc_pkg.sv
package fptrunc_pkg;
  localparam int WORD_W    = 32;
  localparam int BEAT_W    = 128;
  localparam int MAX_TRUNC = 23;
  localparam int TRUNC_W   = 5;
  localparam int ACC_W     = BEAT_W + WORD_W;
  localparam int FILL_W    = $clog2(ACC_W + 1);

  typedef struct packed {
    logic idle;   // no transfer open: next accepted word starts one
    logic take;   // accept the offered word this cycle
    logic flush;  // emit the leftover bits as the closing beat
    logic last;   // accepted word closes the transfer
  } packStrb_t;

  function automatic logic [TRUNC_W-1:0] clampTrunc(input logic [TRUNC_W-1:0] k);
    return (k > TRUNC_W'(MAX_TRUNC)) ? TRUNC_W'(MAX_TRUNC) : k;
  endfunction
endpackage

// File: rtl/fptrunc_pack_ctrl.sv
module fptrunc_pack_ctrl
  import fptrunc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outFree,
  input  logic      spillOver,
  output logic      inReady,
  output packStrb_t strb
);
  logic running;
  logic flushPend;

  always_comb begin
    inReady    = !flushPend && outFree;
    strb.idle  = !running;
    strb.take  = inValid && !flushPend && outFree;
    strb.flush = flushPend && outFree;
    strb.last  = strb.take && inLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      flushPend <= 1'b0;
    end else begin
      if (strb.take) running <= !inLast;
      if (strb.flush) flushPend <= 1'b0;
      else if (strb.last && spillOver) flushPend <= 1'b1;
    end
  end

  // R4: a closing flush only ever follows a word flagged last
  p_flush_after_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushPend) |-> $past(inLast) && $past(inValid));

  // R4: once the closing beat is issued no transfer is open
  p_flush_closes_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> strb.idle);
endmodule

// File: rtl/fptrunc_pack_dp.sv
module fptrunc_pack_dp
  import fptrunc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  packStrb_t          strb,
  input  logic [TRUNC_W-1:0] cfgTrunc,
  input  logic [WORD_W-1:0]  inWord,
  input  logic               outReady,
  output logic               outFree,
  output logic               spillOver,
  output logic               outValid,
  output logic [BEAT_W-1:0]  outBeat,
  output logic               outLast,
  output logic [TRUNC_W-1:0] outTrunc
);
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   sum;
  logic [FILL_W-1:0]  fill;
  logic [FILL_W-1:0]  fieldW;
  logic [FILL_W-1:0]  newFill;
  logic [TRUNC_W-1:0] kReg;
  logic [TRUNC_W-1:0] kUse;
  logic [WORD_W-1:0]  field;

  always_comb begin
    kUse      = strb.idle ? clampTrunc(cfgTrunc) : kReg;
    field     = inWord >> kUse;
    fieldW    = FILL_W'(WORD_W) - FILL_W'(kUse);
    sum       = acc | (ACC_W'(field) << fill);
    newFill   = fill + fieldW;
    spillOver = newFill > FILL_W'(BEAT_W);
    outFree   = !outValid || outReady;
  end

  assign outTrunc = kReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      fill     <= '0;
      kReg     <= '0;
      outValid <= 1'b0;
      outBeat  <= '0;
      outLast  <= 1'b0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (strb.take && strb.idle) kReg <= kUse;
      if (strb.flush) begin
        outBeat  <= acc[BEAT_W-1:0];
        outValid <= 1'b1;
        outLast  <= 1'b1;
        acc      <= '0;
        fill     <= '0;
      end else if (strb.take) begin
        if (newFill >= FILL_W'(BEAT_W)) begin
          outBeat  <= sum[BEAT_W-1:0];
          outValid <= 1'b1;
          outLast  <= strb.last && !spillOver;
          acc      <= sum >> BEAT_W;
          fill     <= newFill - FILL_W'(BEAT_W);
        end else if (strb.last) begin
          outBeat  <= sum[BEAT_W-1:0];
          outValid <= 1'b1;
          outLast  <= 1'b1;
          acc      <= '0;
          fill     <= '0;
        end else begin
          acc  <= sum;
          fill <= newFill;
        end
      end
    end
  end

  p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBeat) && $stable(outLast) && $stable(outTrunc));

  p_trunc_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idle |=> $stable(outTrunc));

  p_trunc_clamped_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outTrunc <= TRUNC_W'(MAX_TRUNC));

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fill < FILL_W'(BEAT_W));
endmodule

// File: rtl/fptrunc_unpack.sv
module fptrunc_unpack
  import fptrunc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TRUNC_W-1:0] trunc,
  input  logic [CNT_W-1:0]   count,
  input  logic               inValid,
  output logic               inReady,
  input  logic [BEAT_W-1:0]  inBeat,
  output logic               outValid,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outWord
);
  localparam logic [WORD_W-1:0] WORD_MASK = {WORD_W{1'b1}};

  logic [ACC_W-1:0]   buffer;
  logic [FILL_W-1:0]  avail;
  logic [FILL_W-1:0]  fieldW;
  logic [CNT_W-1:0]   remain;
  logic [TRUNC_W-1:0] kReg;
  logic               active;

  always_comb begin
    active   = remain != '0;
    fieldW   = FILL_W'(WORD_W) - FILL_W'(kReg);
    outValid = active && (avail >= fieldW);
    inReady  = active && (avail < fieldW);
    outWord  = (buffer[WORD_W-1:0] & (WORD_MASK >> kReg)) << kReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      buffer <= '0;
      avail  <= '0;
      remain <= '0;
      kReg   <= '0;
    end else if (!active) begin
      if (inValid && count != '0) begin
        remain <= count;
        kReg   <= clampTrunc(trunc);
      end
    end else if (outValid && outReady) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) begin
        buffer <= '0;
        avail  <= '0;
      end else begin
        buffer <= buffer >> fieldW;
        avail  <= avail - fieldW;
      end
    end else if (inValid && inReady) begin
      buffer <= buffer | (ACC_W'(inBeat) << avail);
      avail  <= avail + FILL_W'(BEAT_W);
    end
  end

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outWord));

  p_avail_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    avail < FILL_W'(ACC_W));

  p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> avail == '0 && !outValid && !inReady);
endmodule

// File: rtl/fptrunc_codec.sv
module fptrunc_codec
  import fptrunc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TRUNC_W-1:0] cfgTrunc,
  input  logic               pkInValid,
  output logic               pkInReady,
  input  logic [WORD_W-1:0]  pkInWord,
  input  logic               pkInLast,
  output logic               pkOutValid,
  input  logic               pkOutReady,
  output logic [BEAT_W-1:0]  pkOutBeat,
  output logic               pkOutLast,
  output logic [TRUNC_W-1:0] pkOutTrunc,
  input  logic [TRUNC_W-1:0] upTrunc,
  input  logic [CNT_W-1:0]   upCount,
  input  logic               upInValid,
  output logic               upInReady,
  input  logic [BEAT_W-1:0]  upInBeat,
  output logic               upOutValid,
  input  logic               upOutReady,
  output logic [WORD_W-1:0]  upOutWord
);
  packStrb_t strb;
  logic      outFree;
  logic      spillOver;

  fptrunc_pack_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(pkInValid), .inLast(pkInLast),
    .outFree(outFree), .spillOver(spillOver), .inReady(pkInReady), .strb(strb)
  );

  fptrunc_pack_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgTrunc(cfgTrunc), .inWord(pkInWord),
    .outReady(pkOutReady), .outFree(outFree), .spillOver(spillOver),
    .outValid(pkOutValid), .outBeat(pkOutBeat), .outLast(pkOutLast), .outTrunc(pkOutTrunc)
  );

  fptrunc_unpack #(.CNT_W(CNT_W)) unpack_i (
    .clk(clk), .rstN(rstN), .trunc(upTrunc), .count(upCount),
    .inValid(upInValid), .inReady(upInReady), .inBeat(upInBeat),
    .outValid(upOutValid), .outReady(upOutReady), .outWord(upOutWord)
  );
endmodule

// File: tb/fptrunc_codec_tb_top.sv
module fptrunc_codec_tb_top;
  localparam int CNT_W = 16;
  localparam int MAXW  = 64;
  localparam int MAXB  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]   cfgTrunc = '0;
  logic         pkInValid = 1'b0, pkInLast = 1'b0, pkOutReady = 1'b1;
  logic [31:0]  pkInWord = '0;
  logic         pkInReady, pkOutValid, pkOutLast;
  logic [127:0] pkOutBeat;
  logic [4:0]   pkOutTrunc;
  logic [4:0]   upTrunc = '0;
  logic [15:0]  upCount = '0;
  logic         upInValid = 1'b0, upOutReady = 1'b1;
  logic [127:0] upInBeat = '0;
  logic         upInReady, upOutValid;
  logic [31:0]  upOutWord;

  fptrunc_codec #(.CNT_W(CNT_W)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  logic [31:0]  words    [MAXW];
  logic [127:0] expBeats [MAXB];
  logic [127:0] gotBeats [MAXB];
  logic         gotLast  [MAXB];
  logic [4:0]   gotTrunc [MAXB];
  int nExp, nGot;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Builds words and the expected packed beats from R1/R3/R4
  task automatic build(input int n, input int k, input logic [31:0] seed);
    logic [MAXB*128-1:0] bits;
    logic [31:0] s;
    int pos;
    bits = '0;
    s = seed;
    pos = 0;
    for (int w = 0; w < n; w++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      words[w] = s ^ (s << 7);
      for (int b = 0; b < 32 - k; b++) bits[pos + b] = words[w][k + b];
      pos += 32 - k;
    end
    nExp = (pos + 127) / 128;
    for (int j = 0; j < nExp; j++) expBeats[j] = bits[j*128 +: 128];
  endtask

  task automatic run_pack(input int n, input int kcfg, input bit bp, input bit swapCfg, input string tag);
    bit done, fireIn, holdPend;
    logic [127:0] heldBeat;
    int wi, guard, keff;
    keff = (kcfg > 23) ? 23 : kcfg;
    nGot = 0; wi = 0; done = 0; guard = 0; holdPend = 0; heldBeat = '0;
    cfgTrunc = 5'(kcfg);
    pkInValid = 1'b1; pkInWord = words[0]; pkInLast = (n == 1);
    pkOutReady = 1'b1;
    while (!done && guard < 4000) begin
      guard++;
      @(negedge clk);
      if (holdPend) check(pkOutValid && pkOutBeat == heldBeat, {tag, " R7 held beat"}, pkOutBeat, heldBeat);
      holdPend = pkOutValid && !pkOutReady;
      heldBeat = pkOutBeat;
      fireIn = pkInValid && pkInReady;
      if (pkOutValid && pkOutReady && nGot < MAXB) begin
        gotBeats[nGot] = pkOutBeat; gotLast[nGot] = pkOutLast; gotTrunc[nGot] = pkOutTrunc;
        nGot++;
        if (pkOutLast) done = 1;
      end
      @(posedge clk); #1;
      if (fireIn) begin
        wi++;
        if (wi < n) begin pkInWord = words[wi]; pkInLast = (wi == n - 1); end
        else begin pkInValid = 1'b0; pkInLast = 1'b0; end
        if (swapCfg) cfgTrunc = 5'd2;
      end
      pkOutReady = bp ? ((cyc % 3) != 1) : 1'b1;
    end
    pkOutReady = 1'b1;
    check(nGot == nExp, {tag, " R3 R4 beat count"}, 128'(nGot), 128'(nExp));
    for (int j = 0; j < nGot && j < nExp; j++) begin
      check(gotBeats[j] == expBeats[j], {tag, " R1 R3 beat data"}, gotBeats[j], expBeats[j]);
      check(gotLast[j] == (j == nExp - 1), {tag, " R4 last flag"}, 128'(gotLast[j]), 128'(j == nExp - 1));
      check(gotTrunc[j] == 5'(keff), {tag, " R6 reported count"}, 128'(gotTrunc[j]), 128'(keff));
    end
  endtask

  task automatic run_unpack(input int n, input int kcfg, input bit bp, input string tag);
    bit fireB;
    int bi, wi, guard, keff;
    logic [31:0] expW;
    keff = (kcfg > 23) ? 23 : kcfg;
    bi = 0; wi = 0; guard = 0;
    upTrunc = 5'(kcfg); upCount = 16'(n);
    upInValid = 1'b1; upInBeat = expBeats[0]; upOutReady = 1'b1;
    while (wi < n && guard < 4000) begin
      guard++;
      @(negedge clk);
      fireB = upInValid && upInReady;
      if (upOutValid && upOutReady) begin
        expW = words[wi] & (32'hFFFF_FFFF << keff);
        check(upOutWord == expW, {tag, " R8 R10 restored word"}, 128'(upOutWord), 128'(expW));
        wi++;
      end
      @(posedge clk); #1;
      if (fireB) begin
        bi++;
        if (bi < nExp) upInBeat = expBeats[bi]; else upInValid = 1'b0;
      end
      upOutReady = bp ? ((cyc % 4) != 2) : 1'b1;
    end
    upInValid = 1'b0; upOutReady = 1'b1;
    check(wi == n, {tag, " R9 word total"}, 128'(wi), 128'(n));
    check(bi == nExp, {tag, " R9 beats consumed"}, 128'(bi), 128'(nExp));
    @(negedge clk);
    check(!upOutValid && !upInReady, {tag, " R9 back to idle"}, 128'({upOutValid, upInReady}), 128'(0));
    @(posedge clk); #1;
  endtask

  task automatic scenario(input int n, input int kcfg, input bit bp, input bit swapCfg, input logic [31:0] seed, input string tag);
    build(n, (kcfg > 23) ? 23 : kcfg, seed);
    run_pack(n, kcfg, bp, swapCfg, tag);
    run_unpack(n, kcfg, bp, tag);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!pkOutValid && !upOutValid, "R11 outputs idle", 128'({pkOutValid, upOutValid}), 128'(0));
    check(pkInReady && !upInReady, "R11 input readiness", 128'({pkInReady, upInReady}), 128'(2));
    @(posedge clk); #1;
  endtask

  task automatic test_zero_count();
    // R9: a zero word total must not start a transfer
    upCount = '0; upTrunc = 5'd4; upInValid = 1'b1; upInBeat = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!upInReady && !upOutValid, "R9 zero total ignored", 128'({upInReady, upOutValid}), 128'(0));
    upInValid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    test_reset();
    scenario(16, 8, 0, 0, 32'h1111, "exact-fill k8");
    scenario(5, 0, 0, 0, 32'h2222, "R10 lossless k0");
    scenario(20, 30, 0, 0, 32'h3333, "R2 clamp 30");
    scenario(5, 4, 0, 0, 32'h4444, "R4 spill k4");
    scenario(11, 12, 0, 1, 32'h5555, "R5 cfg swap k12");
    scenario(30, 3, 1, 0, 32'h6666, "R7 backpressure k3");
    scenario(1, 23, 0, 0, 32'h7777, "single word k23");
    test_zero_count();
    scenario(9, 17, 1, 1, 32'h8888, "R5 R7 swap+bp k17");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule